// File: doc/BRIEF.md
# Three-Character Pattern Locator

This block checks whether a short pattern of three characters appears inside a reference string of up to five characters. When it does, the block reports the 1-based index where the leftmost occurrence begins. A one-cycle `start` pulse captures the reference characters, the reference length and the pattern. The block then tests one candidate alignment per clock, from the left end toward the right. It stops at the first alignment that matches, or after the last alignment that fits inside the reference.

When the block finishes, it raises `done` for exactly one cycle. At that point `found` and `pos` carry the result, and they keep it until the next accepted `start`. A miss is reported as `found = 0` and `pos = 0`. Character widths, the reference length and the pattern length are parameters. The defaults are 8-bit characters, a 5-character reference and a 3-character pattern.

Top module: `substr_locator`

## Requirements
- R1: On a match, `found` reads 1 and `pos` gives the 1-based index of the reference character where the match begins. Character 1 is the leftmost character. In both `ref_chars` and `pat_chars`, character 1 sits in the most significant byte and later characters follow in descending byte order.
- R2: When no alignment matches, both `found` and `pos` read 0 once `done` pulses.
- R3: When the pattern occurs at several positions, the leftmost one is reported.
- R4: Only alignments whose three characters all lie within the first `ref_len` characters are tested. A `ref_len` below 3 gives no match, and characters beyond `ref_len` never produce a match. A `ref_len` above the reference capacity is treated as the full capacity.
- R5: Alignments are tested one per clock. A match at position k raises `done` on the k-th rising edge after the edge that samples `start`. A miss raises `done` on edge max(1, ref_len-2).
- R6: `done` is high for exactly one cycle. `found` and `pos` then hold their values until the next accepted `start`.
- R7: The inputs are captured on the edge that accepts `start`. A `start` that arrives while a search is running is ignored, and input changes during a search do not affect its result.
- R8: After reset, `found`, `pos` and `done` read 0. While a search is running, `found` and `pos` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search; sampled only while idle |
| ref_chars | input | REF_LEN*CHAR_W | Reference characters, character 1 in the top byte |
| ref_len | input | $clog2(REF_LEN+1) | Number of valid reference characters |
| pat_chars | input | PAT_LEN*CHAR_W | Pattern characters, character 1 in the top byte |
| found | output | 1 | Pattern located |
| pos | output | $clog2(REF_LEN-PAT_LEN+2) | 1-based start index of the match, 0 on a miss |
| done | output | 1 | One-cycle pulse when the search ends |

## Verification
Assertions check four properties on every cycle:
- `done` never lasts two cycles.
- An idle block with no `start` keeps its result stable.
- A zero `found` always comes with a zero `pos`, and a reported position stays within both the alignment range and the captured length.
- The outputs stay cleared during a scan.

Some properties only the bench's directed scenarios can show:
- the leftmost choice among repeated occurrences
- the exact completion latency for each match position and length
- the clamping of oversized lengths
- that `start` pulses and input changes during a search are ignored

// File: rtl/substr_pkg.sv
package substr_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    // Number of alignments that fit completely inside a string of len characters.
    function automatic int fitting_alignments(input int len, input int pat_len);
        return (len >= pat_len) ? (len - pat_len + 1) : 0;
    endfunction

    // Index of the last alignment to visit; at least one cycle is always spent.
    function automatic int final_alignment(input int len, input int pat_len);
        int n;
        n = fitting_alignments(len, pat_len);
        return (n == 0) ? 0 : n - 1;
    endfunction

endpackage

// File: rtl/substr_align_match.sv
module substr_align_match #(
    parameter int CHAR_W  = 8,
    parameter int REF_LEN = 5,
    parameter int PAT_LEN = 3,
    localparam int NUM_ALIGN = REF_LEN - PAT_LEN + 1,
    localparam int LEN_W     = $clog2(REF_LEN + 1)
) (
    input  logic [REF_LEN*CHAR_W-1:0] ref_q,
    input  logic [PAT_LEN*CHAR_W-1:0] pat_q,
    input  logic [LEN_W-1:0]          len_q,
    output logic [NUM_ALIGN-1:0]      hit
);

    logic [NUM_ALIGN-1:0][PAT_LEN-1:0] char_eq;

    for (genvar a = 0; a < NUM_ALIGN; a++) begin : g_align
        for (genvar c = 0; c < PAT_LEN; c++) begin : g_char
            assign char_eq[a][c] =
                (ref_q[(REF_LEN-1-a-c)*CHAR_W +: CHAR_W] == pat_q[(PAT_LEN-1-c)*CHAR_W +: CHAR_W]);
        end
        assign hit[a] = (&char_eq[a]) && (len_q >= LEN_W'(a + PAT_LEN));
    end

endmodule

// File: rtl/substr_scan_ctrl.sv
module substr_scan_ctrl
    import substr_pkg::*;
#(
    parameter int NUM_ALIGN = 3,
    localparam int POS_W    = $clog2(NUM_ALIGN + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [NUM_ALIGN-1:0] hit_i,
    input  logic [POS_W-1:0]     last_i,
    output logic                 capture_o,
    output logic                 found_o,
    output logic [POS_W-1:0]     pos_o,
    output logic                 done_o
);

    scan_state_e      state;
    logic [POS_W-1:0] idx;
    logic             cur_hit;

    assign capture_o = (state == ST_IDLE) && start_i;

    always_comb begin
        cur_hit = 1'b0;
        for (int i = 0; i < NUM_ALIGN; i++) begin
            if (idx == POS_W'(i)) cur_hit = hit_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            idx     <= '0;
            found_o <= 1'b0;
            pos_o   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state   <= ST_SCAN;
                        idx     <= '0;
                        found_o <= 1'b0;
                        pos_o   <= '0;
                    end
                end
                ST_SCAN: begin
                    if (cur_hit) begin
                        found_o <= 1'b1;
                        pos_o   <= idx + POS_W'(1);
                        done_o  <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (idx >= last_i) begin
                        done_o  <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        idx <= idx + POS_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start_i) |=> ($stable(found_o) && $stable(pos_o)));

    assert_miss_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !found_o |-> (pos_o == '0));

    assert_pos_range_R1: assert property (@(posedge clk) disable iff (rst)
        found_o |-> (pos_o >= POS_W'(1) && pos_o <= POS_W'(NUM_ALIGN)));

    assert_scan_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SCAN) |-> (!found_o && pos_o == '0));

endmodule

// File: rtl/substr_locator.sv
module substr_locator
    import substr_pkg::*;
#(
    parameter int CHAR_W  = 8,
    parameter int REF_LEN = 5,
    parameter int PAT_LEN = 3,
    localparam int NUM_ALIGN = REF_LEN - PAT_LEN + 1,
    localparam int LEN_W     = $clog2(REF_LEN + 1),
    localparam int POS_W     = $clog2(NUM_ALIGN + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [REF_LEN*CHAR_W-1:0] ref_chars,
    input  logic [LEN_W-1:0]          ref_len,
    input  logic [PAT_LEN*CHAR_W-1:0] pat_chars,
    output logic                      found,
    output logic [POS_W-1:0]          pos,
    output logic                      done
);

    logic [REF_LEN*CHAR_W-1:0] ref_q;
    logic [PAT_LEN*CHAR_W-1:0] pat_q;
    logic [LEN_W-1:0]          len_q;
    logic [LEN_W-1:0]          len_clamped;
    logic [NUM_ALIGN-1:0]      hit;
    logic [POS_W-1:0]          last_idx;
    logic                      capture;

    assign len_clamped = (ref_len > LEN_W'(REF_LEN)) ? LEN_W'(REF_LEN) : ref_len;
    assign last_idx    = POS_W'(final_alignment(int'(len_q), PAT_LEN));

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
            pat_q <= '0;
            len_q <= '0;
        end else if (capture) begin
            ref_q <= ref_chars;
            pat_q <= pat_chars;
            len_q <= len_clamped;
        end
    end

    substr_align_match #(
        .CHAR_W  (CHAR_W),
        .REF_LEN (REF_LEN),
        .PAT_LEN (PAT_LEN)
    ) u_match (
        .ref_q (ref_q),
        .pat_q (pat_q),
        .len_q (len_q),
        .hit   (hit)
    );

    substr_scan_ctrl #(
        .NUM_ALIGN (NUM_ALIGN)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .hit_i     (hit),
        .last_i    (last_idx),
        .capture_o (capture),
        .found_o   (found),
        .pos_o     (pos),
        .done_o    (done)
    );

    assert_match_in_length_R4: assert property (@(posedge clk) disable iff (rst)
        found |-> (int'(pos) + PAT_LEN - 1 <= int'(len_q)));

    assert_len_capped_R4: assert property (@(posedge clk) disable iff (rst)
        len_q <= LEN_W'(REF_LEN));

endmodule

// File: tb/test_substr_locator.sv
`timescale 1ns/1ps
module test_substr_locator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [39:0] ref_chars = '0;
    logic [2:0]  ref_len = '0;
    logic [23:0] pat_chars = '0;
    logic        found;
    logic [1:0]  pos;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    substr_locator i_substr_locator (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ref_chars (ref_chars),
        .ref_len   (ref_len),
        .pat_chars (pat_chars),
        .found     (found),
        .pos       (pos),
        .done      (done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Launch a search and return the number of negedges until done is seen.
    task automatic launch(input logic [39:0] r, input logic [2:0] len,
                          input logic [23:0] p, input bit poke, output int cyc);
        @(negedge clk);
        ref_chars = r; ref_len = len; pat_chars = p; start = 1'b1;
        cyc = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (cyc == 1) begin
                check("R8", "found during scan", int'(found), 0);
                check("R8", "pos during scan", int'(pos), 0);
                if (poke) begin
                    start = 1'b1;
                    ref_chars = "XXABC"; pat_chars = "ABC"; ref_len = 3'd5;
                end
            end
            if (done) break;
        end
    endtask

    task automatic run_case(input string req, input logic [39:0] r, input logic [2:0] len,
                            input logic [23:0] p, input int exp_found, input int exp_pos,
                            input int exp_cyc, input bit poke);
        int cyc;
        launch(r, len, p, poke, cyc);
        check(req, "found", int'(found), exp_found);
        check(req, "pos", int'(pos), exp_pos);
        check("R5", "done latency", cyc, exp_cyc);
        @(negedge clk);
        check("R6", "done width", int'(done), 0);
        @(negedge clk);
        check("R6", "found held", int'(found), exp_found);
        check("R6", "pos held", int'(pos), exp_pos);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R8", "reset found", int'(found), 0);
        check("R8", "reset pos", int'(pos), 0);
        check("R8", "reset done", int'(done), 0);
        rst = 1'b0;
    endtask

    task automatic t_positions();
        run_case("R1", "ABCDE", 3'd5, "ABC", 1, 1, 2, 1'b0);
        run_case("R1", "ABCDE", 3'd5, "BCD", 1, 2, 3, 1'b0);
        run_case("R1", "ABCDE", 3'd5, "CDE", 1, 3, 4, 1'b0);
    endtask

    task automatic t_miss();
        run_case("R2", "ABCDE", 3'd5, "XYZ", 0, 0, 4, 1'b0);
        run_case("R2", "ABCDE", 3'd5, "ACE", 0, 0, 4, 1'b0);
    endtask

    task automatic t_leftmost();
        run_case("R3", "AAAAA", 3'd5, "AAA", 1, 1, 2, 1'b0);
        run_case("R3", "QABAB", 3'd5, "BAB", 1, 3, 4, 1'b0);
    endtask

    task automatic t_length();
        run_case("R4", "ABCDE", 3'd4, "CDE", 0, 0, 3, 1'b0);
        run_case("R4", "ABCDE", 3'd4, "BCD", 1, 2, 3, 1'b0);
        run_case("R4", "ABCDE", 3'd2, "ABC", 0, 0, 2, 1'b0);
        run_case("R4", "ABCDE", 3'd3, "ABC", 1, 1, 2, 1'b0);
        run_case("R4", "ABCDE", 3'd7, "CDE", 1, 3, 4, 1'b0);
    endtask

    task automatic t_busy_start();
        // Second start and new inputs during the scan must not change the outcome.
        run_case("R7", "ABCDE", 3'd5, "XYZ", 0, 0, 4, 1'b1);
        run_case("R7", "ABCDE", 3'd5, "CDE", 1, 3, 4, 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_positions();
        t_miss();
        t_leftmost();
        t_length();
        t_busy_start();
        repeat (2) @(negedge clk);
        summary();
    end

endmodule